// File: doc/BRIEF.md
# Input Pin Deglitch Filter with Interrupt

This block conditions one general-purpose input pin before the rest of the chip sees it. The raw pin passes through a two-flop synchronizer and an optional inversion. It is then sampled only on a strobe. The strobe is derived from a selectable bit of a free-running counter that many pins share. The filtered level moves to a new value only after enough consecutive strobe samples agree on that value. Short glitches and bounce are therefore rejected, and the rejection window scales with the chosen counter bit.

The filtered level feeds an interrupt stage that works in one of two modes. In level mode the interrupt follows the filtered level. In rising-edge mode a latch records every low-to-high transition of the filtered level. The latch holds until a clear pulse removes it. An enable gates only the interrupt output; the edge latch keeps recording while the enable is low. A full register file would place one instance of this block per pin and drive the configuration, counter and clear inputs.

Top module: `pin_deglitch_irq`

## Requirements
- R1: While and after reset (active-low `rst_n`), `filt_level` is 0, `irq` is 0 and the edge latch is empty.
- R2: The raw pin reaches the sampling point through two clock flops. A strobe in the second clock cycle after a pin change still samples the old value. A strobe in the third cycle samples the new value.
- R3: A sample is taken only in a cycle where `tick_count[rate_sel]` is 1 and was 0 in the previous cycle. A rising edge on any other counter bit takes no sample. A falling edge of the selected bit takes no sample either.
- R4: When `cfg_invert` is 1, the filter sees the complement of the synchronized pin.
- R5: The filtered level takes a new value after `cfg_match_cnt + 1` consecutive samples that differ from it. A sample equal to the current level restarts the run. `cfg_match_cnt` = 0 accepts on the first differing sample, and 15 needs 16 samples.
- R6: `filt_level` changes only at the clock edge where the accepting strobe is sampled. It holds in every other cycle.
- R7: With `cfg_irq_edge` = 0 (level mode), `irq` equals `cfg_irq_en` AND `filt_level`.
- R8: With `cfg_irq_edge` = 1 (rising-edge mode), a 0-to-1 transition of the filtered level sets the edge latch, and `irq` equals `cfg_irq_en` AND the latch. A 1-to-0 transition does not set the latch.
- R9: `irq_clear` = 1 empties the edge latch at the next clock edge. If a rising transition occurs at that same edge, the latch is set instead.
- R10: The edge latch records transitions regardless of `cfg_irq_en`. Raising the enable later exposes a latched event on `irq` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous raw pin level |
| cfg_invert | input | 1 | Invert synchronized pin before filtering |
| cfg_rate_sel | input | 4 | Index of the counter bit whose rising edge is the sample strobe |
| cfg_match_cnt | input | 4 | Extra consecutive differing samples required beyond the first |
| cfg_irq_en | input | 1 | Interrupt output enable |
| cfg_irq_edge | input | 1 | Interrupt mode: 0 level, 1 rising edge |
| tick_count | input | 16 | Shared free-running counter value |
| irq_clear | input | 1 | Clear pulse for the edge latch |
| filt_level | output | 1 | Deglitched pin level |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a rising filtered transition at the same clock edge as a clear pulse. Both depend on a strobe that arrives only once the pin has crossed the synchronizer. The bench drives the counter directly rather than letting it run free. This places the selected bit's rising edge in a chosen cycle, so the clear pulse can be made to coincide with the accepting strobe. The same direct control aligns strobes one and two cycles after a pin change, which covers the synchronizer boundary. It also separates falling edges and rising edges on unselected bits from real strobes.

// File: rtl/pdi_pkg.sv
`timescale 1ns/1ps
package pdi_pkg;

  typedef enum logic {
    IRQ_LEVEL = 1'b0,
    IRQ_RISE  = 1'b1
  } pdi_irq_mode_e;

  // Edge latch update: a new event outranks a clear in the same cycle.
  function automatic logic pdi_latch_next(input logic held, input logic set_evt,
                                          input logic clr);
    return set_evt | (held & ~clr);
  endfunction

  // Interrupt output selection for the two modes.
  function automatic logic pdi_irq_pick(input pdi_irq_mode_e mode, input logic en,
                                        input logic level, input logic held);
    logic src;
    src = (mode == IRQ_RISE) ? held : level;
    return en & src;
  endfunction

endpackage

// File: rtl/pdi_sync.sv
`timescale 1ns/1ps
module pdi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pdi_strobe.sv
`timescale 1ns/1ps
module pdi_strobe #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             strobe_o
);
  logic bit_now;
  logic bit_prev_q;

  assign bit_now = tick_i[sel_i];

  // Reset to 1 so that a selected bit already high at reset release
  // does not produce a spurious sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_prev_q <= 1'b1;
    else        bit_prev_q <= bit_now;
  end

  assign strobe_o = bit_now & ~bit_prev_q;
endmodule

// File: rtl/pdi_filter.sv
`timescale 1ns/1ps
module pdi_filter #(
  parameter int MATCH_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe_i,
  input  logic               sample_i,
  input  logic [MATCH_W-1:0] limit_i,
  output logic               level_o,
  output logic               rise_o
);
  logic               level_q;
  logic [MATCH_W-1:0] run_q;
  logic               differs;
  logic               run_done;
  logic               accept;

  function automatic logic run_reached(input logic [MATCH_W-1:0] run,
                                       input logic [MATCH_W-1:0] limit);
    return run >= limit;
  endfunction

  always_comb begin
    differs  = sample_i ^ level_q;
    run_done = run_reached(run_q, limit_i);
    accept   = strobe_i & differs & run_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      run_q   <= '0;
    end else if (strobe_i) begin
      if (!differs) begin
        run_q <= '0;
      end else if (run_done) begin
        level_q <= sample_i;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;
  assign rise_o  = accept & sample_i;
endmodule

// File: rtl/pdi_irq.sv
`timescale 1ns/1ps
module pdi_irq
  import pdi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          clear_i,
  input  logic          level_i,
  input  logic          en_i,
  input  pdi_irq_mode_e mode_i,
  output logic          irq_o,
  output logic          latch_o
);
  logic held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= pdi_latch_next(held_q, rise_i, clear_i);
  end

  assign latch_o = held_q;
  assign irq_o   = pdi_irq_pick(mode_i, en_i, level_i, held_q);
endmodule

// File: rtl/pin_deglitch_irq.sv
`timescale 1ns/1ps
module pin_deglitch_irq
  import pdi_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MATCH_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pin_raw,
  input  logic                     cfg_invert,
  input  logic [$clog2(CNT_W)-1:0] cfg_rate_sel,
  input  logic [MATCH_W-1:0]       cfg_match_cnt,
  input  logic                     cfg_irq_en,
  input  logic                     cfg_irq_edge,
  input  logic [CNT_W-1:0]         tick_count,
  input  logic                     irq_clear,
  output logic                     filt_level,
  output logic                     irq
);
  localparam int SEL_W = $clog2(CNT_W);

  // Named internal events, visible to the bound checker.
  logic sync_pin;
  logic cond_sample;
  logic strobe_w;
  logic rise_w;
  logic edge_latch;

  pdi_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(pin_raw), .q_o(sync_pin)
  );

  assign cond_sample = sync_pin ^ cfg_invert;

  pdi_strobe #(.CNT_W(CNT_W), .SEL_W(SEL_W)) strobe_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_count), .sel_i(cfg_rate_sel),
    .strobe_o(strobe_w)
  );

  pdi_filter #(.MATCH_W(MATCH_W)) filter_i (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_w), .sample_i(cond_sample),
    .limit_i(cfg_match_cnt), .level_o(filt_level), .rise_o(rise_w)
  );

  pdi_irq irq_i (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_w), .clear_i(irq_clear),
    .level_i(filt_level), .en_i(cfg_irq_en),
    .mode_i(pdi_irq_mode_e'(cfg_irq_edge)),
    .irq_o(irq), .latch_o(edge_latch)
  );
endmodule

// File: rtl/pdi_checker.sv
`timescale 1ns/1ps
module pdi_checker #(
  parameter int MATCH_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               strobe_w,
  input logic               rise_w,
  input logic               cond_sample,
  input logic               edge_latch,
  input logic               filt_level,
  input logic               irq,
  input logic               irq_clear,
  input logic               cfg_irq_en,
  input logic [MATCH_W-1:0] cfg_match_cnt
);
  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_w |=> !strobe_w);

  // R6
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_w |=> $stable(filt_level));

  // R5
  fast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_w && cfg_match_cnt == '0 && cond_sample != filt_level)
      |=> filt_level == $past(cond_sample));

  // R8
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_w |=> edge_latch);

  // R9
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !rise_w) |=> !edge_latch);

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_latch && !irq_clear) |=> edge_latch);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |-> !irq);
endmodule

bind pin_deglitch_irq pdi_checker #(.MATCH_W(MATCH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .strobe_w(strobe_w), .rise_w(rise_w),
  .cond_sample(cond_sample), .edge_latch(edge_latch), .filt_level(filt_level),
  .irq(irq), .irq_clear(irq_clear), .cfg_irq_en(cfg_irq_en),
  .cfg_match_cnt(cfg_match_cnt)
);

// File: tb/pin_deglitch_irq_tb_top.sv
`timescale 1ns/1ps
module pin_deglitch_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_raw = 1'b0;
  logic        cfg_invert = 1'b0;
  logic [3:0]  cfg_rate_sel = 4'd0;
  logic [3:0]  cfg_match_cnt = 4'd0;
  logic        cfg_irq_en = 1'b0;
  logic        cfg_irq_edge = 1'b0;
  logic [15:0] tick_count = 16'd0;
  logic        irq_clear = 1'b0;
  logic        filt_level;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pin_deglitch_irq dut_i (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .cfg_invert(cfg_invert),
    .cfg_rate_sel(cfg_rate_sel), .cfg_match_cnt(cfg_match_cnt),
    .cfg_irq_en(cfg_irq_en), .cfg_irq_edge(cfg_irq_edge),
    .tick_count(tick_count), .irq_clear(irq_clear),
    .filt_level(filt_level), .irq(irq)
  );

  // Vector: [30] invert, [29:26] match count, [25:22] rate select,
  // [21:17] sample count, [16:1] raw pin per sample (bit 0 first), [0] expected level
  localparam logic [30:0] VECS [0:9] = '{
    {1'b0, 4'd0,  4'd0,  5'd1,  16'h0001, 1'b1},
    {1'b0, 4'd2,  4'd3,  5'd2,  16'h0003, 1'b0},
    {1'b0, 4'd2,  4'd7,  5'd3,  16'h0007, 1'b1},
    {1'b0, 4'd2,  4'd15, 5'd4,  16'h000B, 1'b0},
    {1'b1, 4'd0,  4'd1,  5'd1,  16'h0000, 1'b1},
    {1'b1, 4'd1,  4'd2,  5'd2,  16'h0000, 1'b1},
    {1'b0, 4'd1,  4'd5,  5'd4,  16'h0003, 1'b0},
    {1'b0, 4'd15, 4'd9,  5'd16, 16'hFFFF, 1'b1},
    {1'b0, 4'd15, 4'd12, 5'd15, 16'h7FFF, 1'b0},
    {1'b1, 4'd0,  4'd4,  5'd2,  16'h0002, 1'b0}
  };

  task automatic check(input string req, input string what, input logic act,
                       input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0; pin_raw = 1'b0; cfg_invert = 1'b0; cfg_rate_sel = 4'd0;
    cfg_match_cnt = 4'd0; cfg_irq_en = 1'b0; cfg_irq_edge = 1'b0;
    tick_count = 16'd0; irq_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_pin(input logic v);
    pin_raw = v;
    repeat (3) @(negedge clk);
  endtask

  // Rising edge of the selected bit at the next posedge, then low again.
  task automatic do_strobe();
    tick_count[cfg_rate_sel] = 1'b1;
    @(negedge clk);
    tick_count = 16'd0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    reset_dut();
    check("R1", "filt_level after reset", filt_level, 1'b0);
    check("R1", "irq after reset", irq, 1'b0);
    cfg_irq_en = 1'b1; cfg_irq_edge = 1'b1;
    @(negedge clk);
    check("R1", "edge latch empty after reset", irq, 1'b0);

    // R4 R5: table of filter vectors
    for (int v = 0; v < 10; v++) begin
      logic [30:0] e;
      e = VECS[v];
      reset_dut();
      cfg_invert = e[30]; cfg_match_cnt = e[29:26]; cfg_rate_sel = e[25:22];
      for (int s = 0; s < int'(e[21:17]); s++) begin
        set_pin(e[1 + s]);
        do_strobe();
      end
      check(e[30] ? "R4" : "R5", $sformatf("vector %0d final level", v),
            filt_level, e[0]);
    end

    // R3: unselected bit and falling edge of selected bit take no sample
    reset_dut();
    cfg_rate_sel = 4'd6;
    set_pin(1'b1);
    tick_count = 16'hFFBF;
    @(negedge clk); @(negedge clk);
    tick_count = 16'd0;
    @(negedge clk);
    check("R3", "unselected bits rising", filt_level, 1'b0);
    set_pin(1'b0);
    tick_count[6] = 1'b1;
    @(negedge clk);
    set_pin(1'b1);
    tick_count[6] = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R3", "falling edge of selected bit", filt_level, 1'b0);
    do_strobe();
    check("R3", "rising edge of selected bit samples", filt_level, 1'b1);

    // R2: two-flop synchronizer boundary
    reset_dut();
    pin_raw = 1'b1;
    @(negedge clk);
    do_strobe();
    check("R2", "strobe two cycles after pin change", filt_level, 1'b0);
    do_strobe();
    check("R2", "strobe after synchronizer filled", filt_level, 1'b1);

    // R6: level holds between strobes while pin differs
    set_pin(1'b0);
    repeat (4) @(negedge clk);
    check("R6", "no strobe no change", filt_level, 1'b1);

    // R7: level mode
    reset_dut();
    cfg_irq_edge = 1'b0; cfg_irq_en = 1'b1;
    set_pin(1'b1); do_strobe();
    check("R7", "level mode irq high", irq, 1'b1);
    cfg_irq_en = 1'b0;
    @(negedge clk);
    check("R7", "level mode disabled", irq, 1'b0);
    cfg_irq_en = 1'b1;
    set_pin(1'b0); do_strobe();
    check("R7", "level mode follows low", irq, 1'b0);

    // R8 R9: edge mode
    reset_dut();
    cfg_irq_edge = 1'b1; cfg_irq_en = 1'b1;
    set_pin(1'b1); do_strobe();
    check("R8", "rise sets irq", irq, 1'b1);
    set_pin(1'b0); do_strobe();
    check("R8", "irq held after level falls", irq, 1'b1);
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
    check("R9", "clear empties latch", irq, 1'b0);
    set_pin(1'b1); do_strobe();
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
    set_pin(1'b0); do_strobe();
    check("R8", "falling transition does not set", irq, 1'b0);

    // R9: set wins over clear at the same edge
    set_pin(1'b1);
    tick_count[cfg_rate_sel] = 1'b1;
    irq_clear = 1'b1;
    @(negedge clk);
    tick_count = 16'd0; irq_clear = 1'b0;
    check("R9", "set wins over simultaneous clear", irq, 1'b1);

    // R10: latch records while disabled
    reset_dut();
    cfg_irq_edge = 1'b1; cfg_irq_en = 1'b0;
    set_pin(1'b1); do_strobe();
    check("R10", "disabled irq stays low", irq, 1'b0);
    set_pin(1'b0); do_strobe();
    cfg_irq_en = 1'b1;
    #1;
    check("R10", "latched event exposed on enable", irq, 1'b1);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule